// File: doc/BRIEF.md
# Level-1 Triggered Readout Pipeline

The block keeps every bunch crossing's trigger data (tower energies, hit multiplicities and region-of-interest coordinates, packed by the user into one slice word) in a circular pipeline memory. A write pointer moves on every clock. A free-running 12-bit bunch-crossing counter is stored alongside each slice. When a Level-1 accept arrives while readout is enabled, the block reads the slice written a programmable number of crossings earlier. That number matches the trigger latency, and the full depth of 128 crossings covers 3.2 µs at 40 MHz. The captured slice and its crossing number go into a derandomising event FIFO.

A framer drains the FIFO toward a readout driver over a valid/ready word stream. Each event becomes a header word that carries the crossing number, then the slice cut into output words, then a trailer word. A busy level warns upstream logic when the FIFO is close to full. Accepts that find the FIFO full are discarded, and a saturating counter records them.

Top module: `rdo_l1_readout`

## Requirements
- R1: An accepted event's data is the slice presented exactly L cycles before the accept cycle, where L is the value of i_latency (1 to 127) and the value 0 selects L = 128.
- R2: The crossing counter is 12 bits wide and is 0 after reset. It adds one on every clock and wraps from 4095 to 0. In the cycle after an i_bc_reset strobe it reads 0.
- R3: The header word carries, in bits 11:0, the counter value of the crossing whose slice was captured (L cycles before the accept). Bits above 11 are zero.
- R4: An accept presented while i_ro_en is low produces no event and no output word.
- R5: Each frame has exactly 5 words with these kind codes on o_kind: header = 1, three data words = 0, trailer = 2. Data words carry slice bits 15:0, then 31:16, then 47:32. The trailer word holds the value 3, the number of data words.
- R6: A word is consumed only in a cycle where o_valid and i_ready are both high. While o_valid is high and i_ready is low, o_word and o_kind hold.
- R7: With the FIFO empty, an enabled accept in cycle t raises o_valid in cycle t+2.
- R8: The FIFO holds 8 events and releases them in order of acceptance. o_busy is high exactly while 6 or more events are stored.
- R9: An enabled accept whose event reaches a full FIFO is discarded, even if a pop happens in the same cycle. o_ovf_count then adds one, saturating at 255.
- R10: After reset, o_valid, o_busy and o_ovf_count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_slice | input | 48 | Trigger data of the current crossing |
| i_accept | input | 1 | Level-1 accept strobe |
| i_ro_en | input | 1 | Readout enable; accepts are ignored while low |
| i_bc_reset | input | 1 | Clears the crossing counter |
| i_latency | input | 7 | Pipeline latency L, 0 selects 128 |
| i_ready | input | 1 | Readout driver can take a word |
| o_valid | output | 1 | o_word is valid |
| o_kind | output | 2 | Word kind: 1 header, 0 data, 2 trailer |
| o_word | output | 16 | Output word |
| o_busy | output | 1 | FIFO at or above the busy level |
| o_ovf_count | output | 8 | Saturating count of discarded events |

## Verification
Single accepts are given at latencies 1, 5, 7 and 128. Because each crossing carries a distinct slice, an off-by-one in the read address shows as wrong data and a wrong header number. Back-to-back accepts, with the ready input toggling every other cycle, separate correct ordering and word holding from lost or repeated words. Strobes of the crossing reset, and a run long enough to wrap the counter, show whether the header number comes from the sampled crossing rather than the accept crossing. Accepts with the enable low, and a flood of accepts with ready held low, tell gating, busy level, discard-on-full and counter saturation apart.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [1:0] {
    KIND_DATA  = 2'd0,
    KIND_HEAD  = 2'd1,
    KIND_TRAIL = 2'd2
  } word_kind_e;
endpackage

// File: rtl/rdo_bcn_counter.sv
module rdo_bcn_counter #(
  parameter int BCN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_clr,
  output logic [BCN_W-1:0] o_bcn
);
  logic [BCN_W-1:0] bcn_q, bcn_d;

  always_comb begin
    if (i_clr) bcn_d = '0;
    else       bcn_d = bcn_q + BCN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcn_q <= '0;
    else        bcn_q <= bcn_d;
  end

  assign o_bcn = bcn_q;
endmodule

// File: rtl/rdo_pipe_ram.sv
module rdo_pipe_ram #(
  parameter int W     = 60,
  parameter int DEPTH = 128,
  localparam int PA_W = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    i_wdata,
  input  logic [PA_W-1:0] i_latency,
  input  logic            i_rd_en,
  output logic [W-1:0]    o_rdata
);
  logic [W-1:0]    mem [DEPTH];
  logic [PA_W-1:0] wp_q, wp_d, raddr;
  logic [W-1:0]    rd_q;

  always_comb begin
    wp_d  = wp_q + PA_W'(1);
    raddr = wp_q - i_latency;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_q <= '0;
    else        wp_q <= wp_d;
  end

  always_ff @(posedge clk) begin
    mem[wp_q] <= i_wdata;
  end

  always_ff @(posedge clk) begin
    if (i_rd_en) rd_q <= mem[raddr];
  end

  assign o_rdata = rd_q;
endmodule

// File: rtl/rdo_event_fifo.sv
module rdo_event_fifo #(
  parameter int W          = 60,
  parameter int DEPTH      = 8,
  parameter int BUSY_LEVEL = 6,
  parameter int OVF_W      = 8,
  localparam int FA_W  = $clog2(DEPTH),
  localparam int CNT_W = FA_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_push,
  input  logic [W-1:0]     i_data,
  input  logic             i_pop,
  output logic [W-1:0]     o_head,
  output logic             o_empty,
  output logic             o_busy,
  output logic [CNT_W-1:0] o_count,
  output logic [OVF_W-1:0] o_ovf
);
  logic [W-1:0]     mem [DEPTH];
  logic [FA_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [OVF_W-1:0] ovf_q, ovf_d;
  logic             full, push_ok, pop_ok;

  always_comb begin
    full    = (cnt_q == CNT_W'(DEPTH));
    push_ok = i_push && !full;
    pop_ok  = i_pop && (cnt_q != '0);
    wr_d    = push_ok ? wr_q + FA_W'(1) : wr_q;
    rd_d    = pop_ok  ? rd_q + FA_W'(1) : rd_q;
    cnt_d   = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    ovf_d   = ovf_q;
    if (i_push && full && (ovf_q != '1)) ovf_d = ovf_q + OVF_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= i_data;
  end

  assign o_head  = mem[rd_q];
  assign o_empty = (cnt_q == '0);
  assign o_busy  = (cnt_q >= CNT_W'(BUSY_LEVEL));
  assign o_count = cnt_q;
  assign o_ovf   = ovf_q;
endmodule

// File: rtl/rdo_framer.sv
module rdo_framer
  import rdo_pkg::*;
#(
  parameter int SLICE_W = 48,
  parameter int WORD_W  = 16,
  parameter int BCN_W   = 12,
  localparam int NWORD = SLICE_W / WORD_W,
  localparam int ENT_W = BCN_W + SLICE_W,
  localparam int IDX_W = $clog2(NWORD + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_empty,
  input  logic [ENT_W-1:0]  i_head,
  input  logic              i_ready,
  output logic              o_pop,
  output logic              o_valid,
  output logic [1:0]        o_kind,
  output logic [WORD_W-1:0] o_word
);
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               last, xfer;
  logic [BCN_W-1:0]   bcn;
  logic [SLICE_W-1:0] slice;

  always_comb begin
    bcn     = i_head[ENT_W-1 -: BCN_W];
    slice   = i_head[SLICE_W-1:0];
    o_valid = !i_empty;
    last    = (idx_q == IDX_W'(NWORD + 1));
    xfer    = o_valid && i_ready;
    o_pop   = xfer && last;
    idx_d   = idx_q;
    if (xfer) idx_d = last ? '0 : idx_q + IDX_W'(1);
  end

  always_comb begin
    o_kind = KIND_DATA;
    o_word = '0;
    if (idx_q == '0) begin
      o_kind = KIND_HEAD;
      o_word = WORD_W'(bcn);
    end else if (last) begin
      o_kind = KIND_TRAIL;
      o_word = WORD_W'(NWORD);
    end else begin
      for (int k = 0; k < NWORD; k++) begin
        if (idx_q == IDX_W'(k + 1)) o_word = slice[k*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end
endmodule

// File: rtl/rdo_l1_readout.sv
module rdo_l1_readout #(
  parameter int SLICE_W    = 48,
  parameter int WORD_W     = 16,
  parameter int BCN_W      = 12,
  parameter int PIPE_DEPTH = 128,
  parameter int FIFO_DEPTH = 8,
  parameter int BUSY_LEVEL = 6,
  parameter int OVF_W      = 8,
  localparam int PA_W  = $clog2(PIPE_DEPTH),
  localparam int ENT_W = BCN_W + SLICE_W,
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SLICE_W-1:0] i_slice,
  input  logic               i_accept,
  input  logic               i_ro_en,
  input  logic               i_bc_reset,
  input  logic [PA_W-1:0]    i_latency,
  input  logic               i_ready,
  output logic               o_valid,
  output logic [1:0]         o_kind,
  output logic [WORD_W-1:0]  o_word,
  output logic               o_busy,
  output logic [OVF_W-1:0]   o_ovf_count
);
  logic [BCN_W-1:0] bcn_q;
  logic [ENT_W-1:0] cap_data, fifo_head;
  logic             take, acc_q, acc_d, fifo_empty, fifo_pop;
  logic [CNT_W-1:0] fifo_cnt;

  rdo_bcn_counter #(.BCN_W(BCN_W)) u_bcn (
    .clk(clk), .rst_n(rst_n), .i_clr(i_bc_reset), .o_bcn(bcn_q)
  );

  assign take  = i_accept && i_ro_en;
  assign acc_d = take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= 1'b0;
    else        acc_q <= acc_d;
  end

  rdo_pipe_ram #(.W(ENT_W), .DEPTH(PIPE_DEPTH)) u_pipe (
    .clk(clk), .rst_n(rst_n), .i_wdata({bcn_q, i_slice}),
    .i_latency(i_latency), .i_rd_en(take), .o_rdata(cap_data)
  );

  rdo_event_fifo #(
    .W(ENT_W), .DEPTH(FIFO_DEPTH), .BUSY_LEVEL(BUSY_LEVEL), .OVF_W(OVF_W)
  ) u_fifo (
    .clk(clk), .rst_n(rst_n), .i_push(acc_q), .i_data(cap_data),
    .i_pop(fifo_pop), .o_head(fifo_head), .o_empty(fifo_empty),
    .o_busy(o_busy), .o_count(fifo_cnt), .o_ovf(o_ovf_count)
  );

  rdo_framer #(.SLICE_W(SLICE_W), .WORD_W(WORD_W), .BCN_W(BCN_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .i_empty(fifo_empty), .i_head(fifo_head),
    .i_ready(i_ready), .o_pop(fifo_pop), .o_valid(o_valid),
    .o_kind(o_kind), .o_word(o_word)
  );
endmodule

// File: rtl/rdo_l1_readout_chk.sv
module rdo_l1_readout_chk #(
  parameter int WORD_W     = 16,
  parameter int BCN_W      = 12,
  parameter int FIFO_DEPTH = 8,
  parameter int OVF_W      = 8,
  parameter int CNT_W      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              i_ready,
  input logic              i_bc_reset,
  input logic              o_valid,
  input logic [1:0]        o_kind,
  input logic [WORD_W-1:0] o_word,
  input logic              o_busy,
  input logic [OVF_W-1:0]  o_ovf_count,
  input logic [BCN_W-1:0]  bcn_q,
  input logic [CNT_W-1:0]  fifo_cnt
);
  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !i_ready) |=> (o_valid && $stable(o_word) && $stable(o_kind)));

  p_bcn_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    i_bc_reset |=> (bcn_q == '0));

  p_bcn_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !i_bc_reset |=> (bcn_q == BCN_W'($past(bcn_q) + BCN_W'(1))));

  p_trail_then_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && i_ready && o_kind == rdo_pkg::KIND_TRAIL)
      |=> (!o_valid || o_kind == rdo_pkg::KIND_HEAD));

  p_head_then_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && i_ready && o_kind == rdo_pkg::KIND_HEAD)
      |=> (o_valid && o_kind == rdo_pkg::KIND_DATA));

  p_busy_has_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    o_busy |-> o_valid);

  p_fifo_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(FIFO_DEPTH));

  p_ovf_monotonic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt != '0) |=> (o_ovf_count >= $past(o_ovf_count)));
endmodule

bind rdo_l1_readout rdo_l1_readout_chk #(
  .WORD_W(WORD_W), .BCN_W(BCN_W), .FIFO_DEPTH(FIFO_DEPTH),
  .OVF_W(OVF_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .i_ready(i_ready), .i_bc_reset(i_bc_reset),
  .o_valid(o_valid), .o_kind(o_kind), .o_word(o_word), .o_busy(o_busy),
  .o_ovf_count(o_ovf_count), .bcn_q(bcn_q), .fifo_cnt(fifo_cnt)
);

// File: tb/rdo_l1_readout_tb_top.sv
`timescale 1ns/1ps
module rdo_l1_readout_tb_top;
  localparam int SW = 48;
  localparam int HN = 8192;

  logic          clk, rst_n;
  logic [SW-1:0] i_slice;
  logic          i_accept, i_ro_en, i_bc_reset, i_ready;
  logic [6:0]    i_latency;
  logic          o_valid, o_busy;
  logic [1:0]    o_kind;
  logic [15:0]   o_word;
  logic [7:0]    o_ovf_count;

  int checks = 0;
  int errors = 0;
  int tcnt   = 0;
  bit done   = 0;

  rdo_l1_readout dut_i (
    .clk(clk), .rst_n(rst_n), .i_slice(i_slice), .i_accept(i_accept),
    .i_ro_en(i_ro_en), .i_bc_reset(i_bc_reset), .i_latency(i_latency),
    .i_ready(i_ready), .o_valid(o_valid), .o_kind(o_kind), .o_word(o_word),
    .o_busy(o_busy), .o_ovf_count(o_ovf_count)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  // reference model
  logic [59:0] q[$];
  logic [SW-1:0] hs [HN];
  logic [11:0]   hb [HN];
  int          m_idx, m_ovf, m_bcn, cyc, lat;
  bit          pend_v, full_pre;
  logic [59:0] pend_e;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_idx = 0; m_ovf = 0; m_bcn = 0; cyc = 0; pend_v = 0;
    end else begin
      full_pre = (q.size() == 8);
      if (q.size() > 0 && i_ready) begin
        if (m_idx == 4) begin void'(q.pop_front()); m_idx = 0; end
        else m_idx++;
      end
      if (pend_v) begin
        if (!full_pre) q.push_back(pend_e);
        else if (m_ovf < 255) m_ovf++;
      end
      pend_v = i_accept && i_ro_en;
      lat = (i_latency == 0) ? 128 : int'(i_latency);
      if (pend_v) pend_e = {hb[(cyc - lat) % HN], hs[(cyc - lat) % HN]};
      hs[cyc % HN] = i_slice;
      hb[cyc % HN] = 12'(m_bcn);
      m_bcn = i_bc_reset ? 0 : (m_bcn + 1) % 4096;
      cyc++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [1:0]  ek;
    logic [15:0] ew;
    chk(o_valid == (q.size() > 0), "R7,R8,R4 o_valid", o_valid, q.size() > 0);
    chk(o_busy == (q.size() >= 6), "R8 o_busy", o_busy, q.size() >= 6);
    chk(o_ovf_count == 8'(m_ovf), "R9 o_ovf_count", o_ovf_count, m_ovf);
    if (q.size() > 0) begin
      if (m_idx == 0) begin ek = 2'd1; ew = {4'h0, q[0][59:48]}; end
      else if (m_idx == 4) begin ek = 2'd2; ew = 16'd3; end
      else begin ek = 2'd0; ew = q[0][(m_idx-1)*16 +: 16]; end
      chk(o_kind == ek, "R5,R6 o_kind", o_kind, ek);
      if (m_idx == 0) chk(o_word == ew, "R2,R3 header", o_word, ew);
      else chk(o_word == ew, "R1,R5,R6 word", o_word, ew);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (!done) compare_all();
    tcnt++;
    i_slice = {16'(tcnt * 7) ^ 16'h5a5a, 16'(tcnt), ~16'(tcnt * 3)};
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic accept_once(input logic [6:0] l);
    i_latency = l; i_accept = 1; step(); i_accept = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; i_slice = '0; i_accept = 0; i_ro_en = 1; i_bc_reset = 0;
    i_ready = 1; i_latency = 7'd5;
    run(4);
    // R10 reset state
    chk(o_valid == 0, "R10 reset valid", o_valid, 0);
    chk(o_busy == 0, "R10 reset busy", o_busy, 0);
    chk(o_ovf_count == 0, "R10 reset ovf", o_ovf_count, 0);
    rst_n = 1;
    run(200);
    // R1 at several latencies, including 0 meaning 128
    accept_once(7'd5);  run(10);
    accept_once(7'd0);  run(10);
    accept_once(7'd1);  run(10);
    // back-to-back accepts, toggling ready (R6, R8)
    for (int i = 0; i < 4; i++) accept_once(7'd3);
    for (int i = 0; i < 40; i++) begin i_ready = i[0]; step(); end
    i_ready = 1;
    for (int i = 0; i < 5; i++) begin i_ready = i[0]; accept_once(7'd9); end
    for (int i = 0; i < 40; i++) begin i_ready = i[0]; step(); end
    i_ready = 1; run(10);
    // R7: empty FIFO, accept in cycle t, valid in t+2
    i_ready = 0;
    accept_once(7'd4);
    chk(o_valid == 0, "R7 not yet valid at t+1", o_valid, 0);
    step();
    chk(o_valid == 1, "R7 valid at t+2", o_valid, 1);
    chk(o_kind == 2'd1, "R7 header first", o_kind, 1);
    i_ready = 1; run(10);
    // R4: enable low gates accepts
    i_ro_en = 0;
    for (int i = 0; i < 5; i++) accept_once(7'd2);
    run(5);
    chk(o_valid == 0, "R4 no event with enable low", o_valid, 0);
    i_ro_en = 1;
    // R2/R3: counter reset, then tag of sampled crossing
    i_bc_reset = 1; step(); i_bc_reset = 0;
    run(3);
    accept_once(7'd6); run(10);
    accept_once(7'd2); run(10);
    // run past the counter wrap with periodic accepts
    for (int i = 0; i < 15; i++) begin accept_once(7'd7); run(300); end
    // R8/R9: flood with ready low
    i_ready = 0;
    for (int i = 0; i < 270; i++) accept_once(7'd11);
    run(3);
    chk(o_busy == 1, "R8 busy when full", o_busy, 1);
    chk(o_ovf_count == 8'd255, "R9 saturation", o_ovf_count, 255);
    i_ready = 1; run(60);
    chk(o_valid == 0, "R8 drained", o_valid, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule